// File: doc/BRIEF.md
# Chained-Descriptor Translation Table Refill Engine

This block is a bus master that rewrites a rectangular window of a two-dimensional page-translation table from a list of descriptors in memory. Software writes the byte address of the first descriptor to the start register. The engine reads that descriptor, then reads one 32-bit entry for each table slot in the rectangle it names and writes each entry into the table. It then follows the descriptor's link to the next one and stops at a zero link. Progress is reported by four status flags and an 8-bit interrupt status field.

Each descriptor is five 32-bit words at consecutive word addresses. Word 0 packs the left and top corner as {y0[15:0], x0[15:0]}. Word 1 packs the right and bottom corner as {y1[15:0], x1[15:0]}. Word 2 is control: bit 0 enables processing and bits [7:4] select the table id. Word 3 is the entry-data pointer and word 4 is the link pointer. Pointers are 16-byte aligned, and their low four bits are dropped. Memory reads use a request/response port with one read in flight. A write of zero to the start register cancels whatever is in progress.

Top module: `lutrf_engine`

## Requirements
- R1: After reset st_ready=1, st_valid=st_done=st_err=0, irq_stat=0 and irq=0, and no memory read or table write is issued.
- R2: A nonzero write to the start register while st_ready=1 starts a refill. One cycle later st_ready=0 and st_valid, st_done and st_err are all 0.
- R3: The five descriptor words are read from pointer+0, +4, +8, +12 and +16, with the layout given above. Bits [3:0] of the start, data and link pointers are ignored, and every read address is word aligned.
- R4: Entries are read from the data pointer at 4-byte steps in raster order, with x varying fastest from x0 to x1, then y from y0 to y1. Each entry gives exactly one table write with tbl_idx = y*TBL_W + x, tbl_data = the entry and tbl_lut = control bits [7:4].
- R5: A zero link ends the chain. A nonzero link makes the engine fetch and process the descriptor at that address.
- R6: A descriptor whose control bit 0 is clear is skipped: no entry reads and no table writes. Its link is still followed.
- R7: On successful completion st_ready, st_valid and st_done are 1 and st_err is 0, and interrupt bit 1 (end of list) is set.
- R8: Interrupt bit 7 (descriptor finished) is set whenever a descriptor completes, whether it was processed or skipped. Bit 0 (table miss) is never set.
- R9: A descriptor with x1<x0, y1<y0, x1>=TBL_W or y1>=TBL_H stops the engine with st_err=1, st_ready=1 and st_valid=st_done=0. It sets interrupt bit 3, and no table write comes from that descriptor.
- R10: A read response flagged with an error stops the engine with st_err=1 and st_ready=1, and sets interrupt bit 2.
- R11: A zero write to the start register cancels all work and clears st_valid, st_done and st_err. After any read in flight returns, st_ready=1. No further table writes occur, and the cancel sets no interrupt bit.
- R12: A nonzero write to the start register while st_ready=0 is ignored, and the running chain completes unchanged.
- R13: irq_stat bits are cleared by writing ones through irq_clr_we/irq_clr_data. A set in the same cycle wins over a clear. irq is 1 exactly when some bit is set in both irq_stat and irq_en.
- R14: At most one memory read is in flight, and rd_req is never raised while a response is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_we | input | 1 | Start register write strobe |
| desc_wdata | input | AW | Start register value: first descriptor address, or zero to cancel |
| irq_en | input | 8 | Interrupt enable mask |
| irq_clr_we | input | 1 | Interrupt clear strobe |
| irq_clr_data | input | 8 | Ones clear the matching irq_stat bits |
| rd_req | output | 1 | Memory read request, one cycle |
| rd_addr | output | AW | Memory read byte address |
| rd_rvalid | input | 1 | Read response valid |
| rd_rdata | input | 32 | Read response data |
| rd_err | input | 1 | Read response error flag |
| tbl_we | output | 1 | Table write enable |
| tbl_idx | output | IDX_W | Table slot index |
| tbl_data | output | 32 | Table entry value |
| tbl_lut | output | LUT_W | Target table id |
| st_ready | output | 1 | Engine idle |
| st_valid | output | 1 | Last refill fully written |
| st_done | output | 1 | Last refill completed |
| st_err | output | 1 | Last refill stopped on an error |
| irq_stat | output | 8 | Interrupt status field |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds descriptor chains in a memory model and pushes every expected table write into a scoreboard queue. A design that walked the rectangle column-first, or that used the link's low bits, would write the wrong slot or data. A design that did not stop at a zero link would write past the chain's end. Slots at the far right column and bottom row test the index arithmetic and the range check, where an off-by-one would accept or reject the wrong rectangle. A cancel is issued during descriptor fetch, and a nonzero start is issued mid-run. A design that left a response in flight or accepted the second start would produce stray writes or an error. Clearing only the end-of-list bit while the descriptor-finished bit stays set shows whether the mask is applied.

// File: rtl/lutrf_pkg.sv
// Shared definitions for the table refill engine: word size, descriptor
// geometry, interrupt bit positions and controller states.
package lutrf_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 5;
    localparam int IRQ_W      = 8;

    // Interrupt bit positions within the 8-bit field.
    localparam int IRQ_MISS  = 0;   // advisory, never raised here
    localparam int IRQ_EOL   = 1;
    localparam int IRQ_RDERR = 2;
    localparam int IRQ_AREA  = 3;
    localparam int IRQ_FILL  = 7;

    // Descriptor word indices.
    localparam int DW_LO   = 0;
    localparam int DW_HI   = 1;
    localparam int DW_CTRL = 2;
    localparam int DW_DATA = 3;
    localparam int DW_LINK = 4;

    typedef enum logic [2:0] {
        S_IDLE, S_DREQ, S_DWAIT, S_CHECK, S_EREQ, S_EWAIT, S_NEXT, S_DRAIN
    } state_t;
endpackage

// File: rtl/lutrf_raster.sv
// Raster walker: steps (x,y) over a rectangle with x fastest.
// Assumes lo<=hi on both axes when load is asserted (checked by the caller).
module lutrf_raster #(
    parameter int XW = 8,
    parameter int YW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [XW-1:0] x_lo,
    input  logic [XW-1:0] x_hi,
    input  logic [YW-1:0] y_lo,
    input  logic [YW-1:0] y_hi,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y,
    output logic          last
);
    assign last = (x == x_hi) && (y == y_hi);

    // Position register: load the top-left corner, then advance along rows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x <= '0;
            y <= '0;
        end else if (load) begin
            x <= x_lo;
            y <= y_lo;
        end else if (step) begin
            if (x == x_hi) begin
                x <= x_lo;
                y <= y + 1'b1;
            end else begin
                x <= x + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lutrf_irq.sv
// Interrupt status field: sticky bits set by event pulses, cleared by
// writing ones; a set beats a clear in the same cycle. Output is masked OR.
module lutrf_irq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    input  logic [W-1:0] en,
    output logic [W-1:0] stat,
    output logic         irq
);
    logic [W-1:0] clr_mask;
    assign clr_mask = clr_we ? clr_data : '0;
    assign irq      = |(stat & en);

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr_mask) | set_i;
    end
endmodule

// File: rtl/lutrf_engine.sv
// Refill engine top: fetches chained descriptors, walks each rectangle and
// writes one table entry per slot. Assumes the memory answers each request
// exactly once, in order, with any latency of at least one cycle.
module lutrf_engine #(
    parameter int AW    = 32,
    parameter int TBL_W = 256,
    parameter int TBL_H = 128,
    parameter int LUT_W = 4,
    parameter int IDX_W = $clog2(TBL_W * TBL_H)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            desc_we,
    input  logic [AW-1:0]                   desc_wdata,
    input  logic [lutrf_pkg::IRQ_W-1:0]     irq_en,
    input  logic                            irq_clr_we,
    input  logic [lutrf_pkg::IRQ_W-1:0]     irq_clr_data,
    output logic                            rd_req,
    output logic [AW-1:0]                   rd_addr,
    input  logic                            rd_rvalid,
    input  logic [lutrf_pkg::WORD_W-1:0]    rd_rdata,
    input  logic                            rd_err,
    output logic                            tbl_we,
    output logic [IDX_W-1:0]                tbl_idx,
    output logic [lutrf_pkg::WORD_W-1:0]    tbl_data,
    output logic [LUT_W-1:0]                tbl_lut,
    output logic                            st_ready,
    output logic                            st_valid,
    output logic                            st_done,
    output logic                            st_err,
    output logic [lutrf_pkg::IRQ_W-1:0]     irq_stat,
    output logic                            irq
);
    import lutrf_pkg::*;

    localparam int XW = $clog2(TBL_W);
    localparam int YW = $clog2(TBL_H);
    localparam logic [IDX_W-1:0] ROW_STRIDE = IDX_W'(TBL_W);
    localparam logic [AW-1:0]    ALIGN_MASK = ~AW'(15);

    state_t                               state;
    logic [AW-1:0]                        desc_ptr, eptr;
    logic [2:0]                           widx;
    logic [DESC_WORDS-1:0][WORD_W-1:0]    dw;
    logic                                 valid_q, done_q, err_q;
    logic [IRQ_W-1:0]                     irq_set;

    // Descriptor field views.
    logic [15:0]   f_x0, f_y0, f_x1, f_y1;
    logic          f_start;
    logic [AW-1:0] f_data, f_link;
    assign f_x0    = dw[DW_LO][15:0];
    assign f_y0    = dw[DW_LO][31:16];
    assign f_x1    = dw[DW_HI][15:0];
    assign f_y1    = dw[DW_HI][31:16];
    assign f_start = dw[DW_CTRL][0];
    assign f_data  = AW'(dw[DW_DATA]) & ALIGN_MASK;
    assign f_link  = AW'(dw[DW_LINK]) & ALIGN_MASK;

    logic bad_area;
    assign bad_area = (f_x1 < f_x0) || (f_y1 < f_y0) ||
                      (32'(f_x1) >= TBL_W) || (32'(f_y1) >= TBL_H);

    logic abort, in_flight, resp_ok;
    assign abort     = desc_we && (desc_wdata == '0);
    assign in_flight = (state == S_DREQ) || (state == S_EREQ) ||
                       (((state == S_DWAIT) || (state == S_EWAIT)) && !rd_rvalid) ||
                       ((state == S_DRAIN) && !rd_rvalid);
    assign resp_ok   = rd_rvalid && !rd_err;

    // Raster walker for the current rectangle.
    logic          r_load, r_step, r_last;
    logic [XW-1:0] r_x;
    logic [YW-1:0] r_y;
    assign r_load = (state == S_CHECK) && !bad_area && f_start && !abort;
    assign r_step = (state == S_EWAIT) && resp_ok && !r_last && !abort;

    lutrf_raster #(.XW(XW), .YW(YW)) i_raster (
        .clk(clk), .rst_n(rst_n), .load(r_load), .step(r_step),
        .x_lo(f_x0[XW-1:0]), .x_hi(f_x1[XW-1:0]),
        .y_lo(f_y0[YW-1:0]), .y_hi(f_y1[YW-1:0]),
        .x(r_x), .y(r_y), .last(r_last)
    );

    // Read port: one-cycle request in the request states.
    always_comb begin
        rd_req  = (state == S_DREQ) || (state == S_EREQ);
        rd_addr = '0;
        if (state == S_DREQ)      rd_addr = desc_ptr + AW'({widx, 2'b00});
        else if (state == S_EREQ) rd_addr = eptr;
    end

    // Interrupt event pulses derived from the controller state.
    always_comb begin
        irq_set = '0;
        if (!abort) begin
            irq_set[IRQ_FILL]  = (state == S_NEXT);
            irq_set[IRQ_EOL]   = (state == S_NEXT) && (f_link == '0);
            irq_set[IRQ_AREA]  = (state == S_CHECK) && bad_area;
            irq_set[IRQ_RDERR] = ((state == S_DWAIT) || (state == S_EWAIT)) &&
                                 rd_rvalid && rd_err;
        end
    end

    lutrf_irq #(.W(IRQ_W)) i_irq (
        .clk(clk), .rst_n(rst_n), .set_i(irq_set),
        .clr_we(irq_clr_we), .clr_data(irq_clr_data), .en(irq_en),
        .stat(irq_stat), .irq(irq)
    );

    assign st_ready = (state == S_IDLE);
    assign st_valid = valid_q;
    assign st_done  = done_q;
    assign st_err   = err_q;

    // Controller: descriptor fetch, area check, entry walk, chaining, cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            desc_ptr <= '0;
            eptr     <= '0;
            widx     <= '0;
            dw       <= '0;
            valid_q  <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            tbl_we   <= 1'b0;
            tbl_idx  <= '0;
            tbl_data <= '0;
            tbl_lut  <= '0;
        end else begin
            tbl_we <= 1'b0;
            if (abort) begin
                valid_q <= 1'b0;
                done_q  <= 1'b0;
                err_q   <= 1'b0;
                state   <= in_flight ? S_DRAIN : S_IDLE;
            end else begin
                case (state)
                    S_IDLE: if (desc_we) begin
                        desc_ptr <= desc_wdata & ALIGN_MASK;
                        widx     <= '0;
                        valid_q  <= 1'b0;
                        done_q   <= 1'b0;
                        err_q    <= 1'b0;
                        state    <= S_DREQ;
                    end
                    S_DREQ: state <= S_DWAIT;
                    S_DWAIT: if (rd_rvalid) begin
                        if (rd_err) begin
                            err_q <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            dw[widx] <= rd_rdata;
                            if (widx == 3'(DESC_WORDS - 1)) begin
                                state <= S_CHECK;
                            end else begin
                                widx  <= widx + 1'b1;
                                state <= S_DREQ;
                            end
                        end
                    end
                    S_CHECK: begin
                        if (bad_area) begin
                            err_q <= 1'b1;
                            state <= S_IDLE;
                        end else if (!f_start) begin
                            state <= S_NEXT;
                        end else begin
                            eptr    <= f_data;
                            tbl_lut <= dw[DW_CTRL][4 +: LUT_W];
                            state   <= S_EREQ;
                        end
                    end
                    S_EREQ: state <= S_EWAIT;
                    S_EWAIT: if (rd_rvalid) begin
                        if (rd_err) begin
                            err_q <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            tbl_we   <= 1'b1;
                            tbl_idx  <= IDX_W'(r_y) * ROW_STRIDE + IDX_W'(r_x);
                            tbl_data <= rd_rdata;
                            eptr     <= eptr + AW'(4);
                            state    <= r_last ? S_NEXT : S_EREQ;
                        end
                    end
                    S_NEXT: begin
                        if (f_link == '0) begin
                            valid_q <= 1'b1;
                            done_q  <= 1'b1;
                            state   <= S_IDLE;
                        end else begin
                            desc_ptr <= f_link;
                            widx     <= '0;
                            state    <= S_DREQ;
                        end
                    end
                    S_DRAIN: if (rd_rvalid) state <= S_IDLE;
                    default: state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/lutrf_engine_chk.sv
// Protocol and status checker for lutrf_engine, attached by bind.
module lutrf_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          desc_we,
    input logic [AW-1:0] desc_wdata,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          rd_rvalid,
    input logic          rd_err,
    input logic          tbl_we,
    input logic          st_ready,
    input logic          st_valid,
    input logic          st_done,
    input logic          st_err,
    input logic [7:0]    irq_stat
);
    // Tracks whether a read is in flight, independent of the controller.
    logic pend_q;
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (rd_req)    pend_q <= 1'b1;
        else if (rd_rvalid) pend_q <= 1'b0;
    end

    a_r14_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !pend_q);
    a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[1:0] == 2'b00));
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        st_ready |-> !rd_req);
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ready && desc_we && desc_wdata != '0) |=> (!st_ready && !st_valid && !st_done && !st_err));
    a_r11_cancel_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_we && desc_wdata == '0) |=> (!st_valid && !st_done && !st_err));
    a_r4_write_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> $past(rd_rvalid && !rd_err));
    a_r7_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |-> (st_ready && st_valid && !st_err));
    a_r7_eol_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_stat[1]) |-> st_done);
    a_r9_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
        st_err |-> (st_ready && !st_done));
    a_r8_no_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_stat[0]);
endmodule

bind lutrf_engine lutrf_engine_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_lutrf_engine.sv
// Scoreboard bench: tasks build descriptor chains in a memory model and queue
// the expected table writes; a monitor pops and compares each write.
module test_lutrf_engine;
    localparam int AW = 32;
    localparam int IW = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          desc_we = 1'b0;
    logic [AW-1:0] desc_wdata = '0;
    logic [7:0]    irq_en = 8'h7E;
    logic          irq_clr_we = 1'b0;
    logic [7:0]    irq_clr_data = '0;
    logic          rd_req, rd_rvalid, rd_err;
    logic [AW-1:0] rd_addr;
    logic [31:0]   rd_rdata;
    logic          tbl_we;
    logic [IW-1:0] tbl_idx;
    logic [31:0]   tbl_data;
    logic [3:0]    tbl_lut;
    logic          st_ready, st_valid, st_done, st_err, irq;
    logic [7:0]    irq_stat;

    lutrf_engine i_lutrf_engine (.*);

    // Memory model: 2 KB of words, two-cycle latency, error above 0x7FF.
    logic [31:0] mem [0:511];
    logic        p_v = 1'b0;
    logic [AW-1:0] p_a = '0;
    initial begin rd_rvalid = 1'b0; rd_rdata = '0; rd_err = 1'b0; end
    always @(posedge clk) begin
        p_v       <= rd_req;
        p_a       <= rd_addr;
        rd_rvalid <= p_v;
        rd_rdata  <= mem[p_a[10:2]];
        rd_err    <= p_v && (p_a[15:11] != 0);
    end

    typedef struct packed { logic [IW-1:0] idx; logic [31:0] data; logic [3:0] lut; } wr_t;
    wr_t exp_q[$];
    int n_checks = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: every table write must match the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && tbl_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4", "unexpected table write idx", 32'(tbl_idx), 32'hFFFF_FFFF);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                check(tbl_idx == e.idx, "R4", "table idx", 32'(tbl_idx), 32'(e.idx));
                check(tbl_data == e.data, "R4", "table data", tbl_data, e.data);
                check(tbl_lut == e.lut, "R4", "table id", 32'(tbl_lut), 32'(e.lut));
            end
        end
    end

    task automatic put(input logic [AW-1:0] a, input logic [31:0] v);
        mem[a[10:2]] = v;
    endtask

    task automatic put_desc(input logic [AW-1:0] base, input int x0, input int y0,
                            input int x1, input int y1, input bit en, input int lut,
                            input logic [31:0] data, input logic [31:0] link);
        put(base,      {16'(y0), 16'(x0)});
        put(base + 4,  {16'(y1), 16'(x1)});
        put(base + 8,  {24'h0, 4'(lut), 3'b0, en});
        put(base + 12, data);
        put(base + 16, link);
    endtask

    // Driver: fills entry data and queues the expected writes in raster order.
    task automatic load_area(input int x0, input int y0, input int x1, input int y1,
                             input int lut, input logic [AW-1:0] data, input int seed,
                             input bit expect_it);
        int k = 0;
        for (int y = y0; y <= y1; y++) begin
            for (int x = x0; x <= x1; x++) begin
                logic [31:0] v;
                v = 32'hA000_0000 | (32'(seed) << 16) | 32'(k);
                put(data + AW'(4 * k), v);
                if (expect_it) exp_q.push_back('{idx: IW'(y * 256 + x), data: v, lut: 4'(lut)});
                k++;
            end
        end
    endtask

    task automatic write_start(input logic [AW-1:0] v);
        @(negedge clk);
        desc_we = 1'b1;
        desc_wdata = v;
        @(negedge clk);
        desc_we = 1'b0;
        desc_wdata = '0;
    endtask

    task automatic clear_irq(input logic [7:0] m);
        @(negedge clk);
        irq_clr_we = 1'b1;
        irq_clr_data = m;
        @(negedge clk);
        irq_clr_we = 1'b0;
        irq_clr_data = '0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (!st_ready && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(st_ready, "R14", "engine returned to idle", 32'(st_ready), 32'd1);
    endtask

    task automatic check_status(input string req, input bit v, input bit d, input bit e,
                                input logic [7:0] is);
        check(st_ready == 1'b1, req, "ready", 32'(st_ready), 32'd1);
        check(st_valid == v, req, "valid", 32'(st_valid), 32'(v));
        check(st_done == d, req, "done", 32'(st_done), 32'(d));
        check(st_err == e, req, "err", 32'(st_err), 32'(e));
        check(irq_stat == is, req, "irq status", 32'(irq_stat), 32'(is));
        check(exp_q.size() == 0, req, "writes outstanding", 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(st_ready && !st_valid && !st_done && !st_err, "R1", "status after reset",
              {28'h0, st_ready, st_valid, st_done, st_err}, 32'h8);
        check(irq_stat == 0 && !irq, "R1", "irq after reset", 32'(irq_stat), 32'h0);
        check(!rd_req && !tbl_we, "R1", "quiet after reset", {30'h0, rd_req, tbl_we}, 32'h0);

        // R3 R4 R5 R12: two-descriptor chain, link with low bits set, far-right column
        put_desc(32'h100, 2, 1, 4, 2, 1'b1, 3, 32'h200, 32'h149);
        load_area(2, 1, 4, 2, 3, 32'h200, 1, 1'b1);
        put_desc(32'h140, 255, 0, 255, 1, 1'b1, 5, 32'h28C, 32'h0);
        load_area(255, 0, 255, 1, 5, 32'h280, 2, 1'b1);
        put_desc(32'h300, 5, 0, 3, 0, 1'b1, 1, 32'h380, 32'h0);
        write_start(32'h105);
        // R2: started, status cleared
        check(!st_ready && !st_done, "R2", "busy after start", {30'h0, st_ready, st_done}, 32'h0);
        repeat (4) @(negedge clk);
        write_start(32'h300);   // R12: must be ignored
        wait_idle();
        // R7 R8: success flags, end-of-list and descriptor-finished bits
        check_status("R7", 1'b1, 1'b1, 1'b0, 8'h82);
        check(irq == 1'b1, "R13", "irq with end-of-list enabled", 32'(irq), 32'd1);
        clear_irq(8'h02);
        check(irq_stat == 8'h80, "R13", "partial clear", 32'(irq_stat), 32'h80);
        check(irq == 1'b0, "R13", "finished bit masked by 0x7E", 32'(irq), 32'd0);
        clear_irq(8'hFF);
        check(irq_stat == 8'h00, "R13", "full clear", 32'(irq_stat), 32'h0);

        // R6: skipped descriptor then bottom-row single slot
        put_desc(32'h180, 0, 0, 1, 1, 1'b0, 2, 32'h400, 32'h1C0);
        load_area(0, 0, 1, 1, 2, 32'h400, 3, 1'b0);
        put_desc(32'h1C0, 0, 127, 0, 127, 1'b1, 9, 32'h440, 32'h0);
        load_area(0, 127, 0, 127, 9, 32'h440, 4, 1'b1);
        write_start(32'h180);
        wait_idle();
        check_status("R6", 1'b1, 1'b1, 1'b0, 8'h82);
        clear_irq(8'hFF);

        // R9: x1 < x0
        write_start(32'h300);
        wait_idle();
        check_status("R9", 1'b0, 1'b0, 1'b1, 8'h08);
        clear_irq(8'hFF);
        // R9: y1 beyond table height
        put_desc(32'h320, 0, 120, 0, 128, 1'b1, 1, 32'h380, 32'h0);
        write_start(32'h320);
        wait_idle();
        check_status("R9", 1'b0, 1'b0, 1'b1, 8'h08);
        clear_irq(8'hFF);

        // R10: entry read from an erroring address
        put_desc(32'h340, 0, 0, 1, 0, 1'b1, 1, 32'h1000, 32'h0);
        write_start(32'h340);
        wait_idle();
        check_status("R10", 1'b0, 1'b0, 1'b1, 8'h04);
        clear_irq(8'hFF);

        // R11: cancel during descriptor fetch
        write_start(32'h100);
        repeat (2) @(negedge clk);
        write_start(32'h0);
        wait_idle();
        repeat (20) @(negedge clk);
        check_status("R11", 1'b0, 1'b0, 1'b0, 8'h00);

        // R5: engine recovers and a single descriptor completes
        load_area(255, 0, 255, 1, 5, 32'h280, 2, 1'b1);
        write_start(32'h140);
        wait_idle();
        check_status("R5", 1'b1, 1'b1, 1'b0, 8'h82);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R14 watchdog expired: actual %h expected %h", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule